// File: doc/BRIEF.md
# Synchronous Serial Port with Master and Slave Modes

This block is a full-duplex synchronous serial port that sits on a small CPU register bus. In master mode it makes the serial clock from the system clock and exchanges one byte with a peripheral. In slave mode it follows a clock and a select line driven from outside. Every exchange moves eight bits out and eight bits in at the same time. Clock polarity, clock phase and bit order can each be set, and in master mode a 2-bit field picks the bit rate.

Software writes a byte to the data register. In master mode that write also starts the exchange. When the byte is complete, the received value is copied into a read buffer and the done flag and interrupt are raised. Two error flags are provided. A collision flag is set when the data register is written during a transfer. In slave mode, an overflow flag is set when a byte completes while the done flag is still pending. To clear the flags, software reads the status register and then accesses the data register.

Top module: `serial_xchg`

Register map:

| Address | Register | Bits |
|---|---|---|
| 0 | Control | bit 7 enable, bit 6 master, bit 5 clock polarity, bit 4 clock phase, bit 3 LSB first, bit 2 mode (must be held at 1), bits 1:0 rate |
| 1 | Status | bit 7 done, bit 6 collision, bit 5 overflow, other bits zero |
| 2 | Data | write loads the transmit byte, read returns the read buffer |

## Requirements
- R1: After reset, control reads 8'h04, status reads 8'h00, `irq` is 0 and `sclk_o` is 0.
- R2: A master transfer drives 8 bits on `mosi_o` and samples 8 bits from `miso_i`, in any of the four polarity/phase combinations. With phase 0, sampling happens on the leading edge; with phase 1, on the trailing edge. The sampled byte is then read back at address 2.
- R3: With control bit 3 set, the LSB is sent and received first; with it clear, the MSB goes first.
- R4: In master mode, `sclk_o` rests at the polarity level when no transfer is running, and it makes exactly 16 transitions per transfer.
- R5: In master mode, consecutive `sclk_o` transitions are spaced 2, 4, 8 or 32 system clocks apart (the system clock divided by 4, 8, 16 or 64) for rate codes 0 to 3.
- R6: A data write during a transfer sets status bit 6 and leaves the byte being shifted unchanged.
- R7: In slave mode with `ss_n_i` low, the block shifts its loaded byte out on `miso_o` and receives the `mosi_i` byte, following `sclk_i` with the configured polarity, phase and order.
- R8: In slave mode, a byte that completes while done is still set raises status bit 5, and the read buffer keeps the earlier byte.
- R9: If `ss_n_i` rises before the eighth bit, the partial byte is dropped and done is not set; the next full byte is received correctly.
- R10: Flags are cleared only by a status read followed by a data-register access; a data access with no prior status read leaves them set.
- R11: `irq` is high exactly while the done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects on status and data) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Transfer-complete interrupt |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
Register reads settle within the same cycle as the address. Control writes take effect on the next edge. A master transfer produces its first clock edge one half-period after the next divider boundary. Done and `irq` rise on the same system edge as the final clock transition, so the bench waits three cycles after seeing `irq` before it reads. Slave-side inputs pass through a two-stage synchroniser, so the slave reacts about three cycles after each pin change. The bench therefore holds each half period for eight cycles, samples `miso_o` just before it drives a sample edge, and waits eight cycles after the last edge before reading status.

// File: rtl/serial_xchg.sv
module serial_xchg #(
  parameter int DIV0 = 4,
  parameter int DIV1 = 8,
  parameter int DIV2 = 16,
  parameter int DIV3 = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sclk_o,
  input  logic       sclk_i,
  output logic       mosi_o,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       miso_i,
  input  logic       ss_n_i
);
  localparam int CW = $clog2(DIV3 / 2) + 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [4:0] LAST_EDGE = 5'd15;

  logic [7:0] ctrl, sh, rx, rbuf;
  logic done_f, wcol_f, ovf_f, armed;
  logic m_pend, m_act, sclk_q;
  logic [4:0] ecnt;
  logic [CW-1:0] dcnt, half;
  logic [1:0] ss_s, mo_s;
  logic [2:0] sk_s;

  wire en   = ctrl[7];
  wire mst  = ctrl[6];
  wire cpol = ctrl[5];
  wire cpha = ctrl[4];
  wire lsbf = ctrl[3];
  wire [1:0] rate = ctrl[1:0];

  always_comb begin
    case (rate)
      2'd0:    half = CW'(DIV0 / 2);
      2'd1:    half = CW'(DIV1 / 2);
      2'd2:    half = CW'(DIV2 / 2);
      default: half = CW'(DIV3 / 2);
    endcase
  end

  wire tick    = (dcnt == half - 1'b1);
  wire ss_low  = en & ~mst & ~ss_s[1];
  wire edge_ev = mst ? (en & m_act & tick) : (ss_low & (sk_s[1] ^ sk_s[2]));
  wire smp     = edge_ev & (ecnt[0] == cpha);
  wire shf     = edge_ev & (ecnt[0] != cpha) & (ecnt != 5'd0) & (ecnt != LAST_EDGE);
  wire fin     = edge_ev & (ecnt == LAST_EDGE);
  wire in_bit  = mst ? miso_i : mo_s[1];
  wire [7:0] rx_nx = !smp ? rx : (lsbf ? {in_bit, rx[7:1]} : {rx[6:0], in_bit});
  wire busy    = mst ? (m_act | m_pend) : (ss_low & (ecnt != 5'd0));
  wire d_wr    = wr_en & (addr == A_DATA);
  wire d_acc   = (wr_en | rd_en) & (addr == A_DATA);
  wire s_rd    = rd_en & (addr == A_STAT);
  wire head    = lsbf ? sh[0] : sh[7];

  assign sclk_o = sclk_q;
  assign mosi_o = head;
  assign miso_o = head;
  assign irq    = done_f;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_STAT:  rdata = {done_f, wcol_f, ovf_f, 5'd0};
      A_DATA:  rdata = rbuf;
      default: rdata = 8'd0;
    endcase
  end

  // pin synchronisers for slave mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_s <= '0;
      ss_s <= 2'b11;
      mo_s <= '0;
    end else begin
      sk_s <= {sk_s[1:0], sclk_i};
      ss_s <= {ss_s[0], ss_n_i};
      mo_s <= {mo_s[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= 8'h04;
    else if (wr_en && addr == A_CTRL) ctrl <= wdata;
  end

  // master rate divider, start and clock generation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      m_pend <= 1'b0;
      m_act  <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      if (!en || !mst || tick) dcnt <= '0;
      else dcnt <= dcnt + 1'b1;
      if (!en || !mst) begin
        m_pend <= 1'b0;
        m_act  <= 1'b0;
      end else begin
        if (d_wr && !busy) m_pend <= 1'b1;
        if (tick && m_pend && !m_act) begin
          m_act  <= 1'b1;
          m_pend <= 1'b0;
        end
        if (fin) m_act <= 1'b0;
      end
      if (m_act && tick) sclk_q <= ~sclk_q;
      else if (!m_act) sclk_q <= cpol;
    end
  end

  // shared edge counter and shift registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt <= '0;
      sh   <= '0;
      rx   <= '0;
    end else begin
      if (!en || (mst && !m_act) || (!mst && !ss_low) || fin) ecnt <= '0;
      else if (edge_ev) ecnt <= ecnt + 1'b1;
      rx <= rx_nx;
      if (d_wr && !busy) sh <= wdata;
      else if (shf) sh <= lsbf ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
    end
  end

  // status flags and read buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      wcol_f <= 1'b0;
      ovf_f  <= 1'b0;
      armed  <= 1'b0;
      rbuf   <= '0;
    end else begin
      if (s_rd) armed <= 1'b1;
      if (d_acc && armed) begin
        armed  <= 1'b0;
        done_f <= 1'b0;
        wcol_f <= 1'b0;
        ovf_f  <= 1'b0;
      end
      if (d_wr && busy) wcol_f <= 1'b1;
      if (fin) begin
        if (!mst && done_f) ovf_f <= 1'b1;
        else begin
          done_f <= 1'b1;
          rbuf   <= rx_nx;
        end
      end
    end
  end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_act && $past(!m_act) && $stable(cpol)) |-> sclk_o == cpol);

  assert_done_from_last_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(fin));

  assert_ovf_slave_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_f) |-> $past(!mst));

  assert_ovf_keeps_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_f) |-> $stable(rbuf));

  assert_collision_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && busy && !shf) |=> $stable(sh));

endmodule

// File: tb/tb_serial_xchg.sv
`timescale 1ns/1ps
module tb_serial_xchg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, sclk_o, mosi_o, miso_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  serial_xchg dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .sclk_o(sclk_o), .sclk_i(sclk_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;

  // external slave model used by master tests
  bit mdl_on = 0, m_cpol, m_cpha, m_lsbf, prev_sk;
  logic [7:0] mpat, cap;
  int bi, edges, last_e, spmin, spmax;

  function automatic int ord(input bit lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdl_on && sclk_o != prev_sk) begin
      edges = edges + 1;
      if (edges > 1) begin
        if (cyc - last_e < spmin) spmin = cyc - last_e;
        if (cyc - last_e > spmax) spmax = cyc - last_e;
      end
      last_e = cyc;
      if ((sclk_o != m_cpol) ^ m_cpha) begin
        if (bi < 8) cap[ord(m_lsbf, bi)] = mosi_o;
        bi = bi + 1;
        if (bi < 8) miso_i = mpat[ord(m_lsbf, bi)];
      end
    end
    prev_sk = sclk_o;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  task automatic flush();
    logic [7:0] d;
    cpu_rd(2'd1, d); cpu_rd(2'd2, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    cpu_rd(2'd0, d); chk(d == 8'h04, "R1 ctrl", d, 8'h04);
    cpu_rd(2'd1, d); chk(d == 8'h00, "R1 status", d, 0);
    cpu_rd(2'd2, d);
  endtask

  task automatic t_master(input bit cpol, input bit cpha, input bit lsbf, input logic [1:0] rate,
                          input logic [7:0] tx, input logic [7:0] pat);
    logic [7:0] d;
    int hexp;
    hexp = (rate == 0) ? 2 : (rate == 1) ? 4 : (rate == 2) ? 8 : 32;
    cpu_wr(2'd0, {1'b1, 1'b1, cpol, cpha, lsbf, 1'b1, rate});
    repeat (3) @(negedge clk);
    chk(sclk_o == cpol, "R4 idle level", sclk_o, cpol);
    m_cpol = cpol; m_cpha = cpha; m_lsbf = lsbf; mpat = pat;
    bi = 0; edges = 0; spmin = 1000000; spmax = 0; cap = '0;
    miso_i = pat[ord(lsbf, 0)]; prev_sk = sclk_o; mdl_on = 1;
    cpu_wr(2'd2, tx);
    wait_irq();
    repeat (3) @(negedge clk);
    mdl_on = 0;
    chk(irq == 1'b1, "R11 irq on done", irq, 1);
    chk(cap == tx, lsbf ? "R3 lsb-first mosi" : "R2 mosi byte", cap, tx);
    chk(edges == 16, "R4 edge count", edges, 16);
    chk(sclk_o == cpol, "R4 rest level", sclk_o, cpol);
    chk(spmin == hexp && spmax == hexp, "R5 half period", spmax, hexp);
    cpu_rd(2'd1, d); chk(d == 8'h80, "R2 status done", d, 8'h80);
    cpu_rd(2'd2, d); chk(d == pat, lsbf ? "R3 lsb-first rx" : "R2 rx byte", d, pat);
    chk(irq == 1'b0, "R10 cleared", irq, 0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    cpu_wr(2'd0, 8'b1100_0111);
    repeat (3) @(negedge clk);
    m_cpol = 0; m_cpha = 0; m_lsbf = 0; mpat = 8'h5A;
    bi = 0; edges = 0; spmin = 1000000; spmax = 0; cap = '0;
    miso_i = mpat[7]; prev_sk = sclk_o; mdl_on = 1;
    cpu_wr(2'd2, 8'hC3);
    repeat (100) @(negedge clk);
    cpu_wr(2'd2, 8'h0F);
    cpu_rd(2'd1, d); chk(d == 8'h40, "R6 collision flag", d, 8'h40);
    wait_irq();
    repeat (3) @(negedge clk);
    mdl_on = 0;
    chk(cap == 8'hC3, "R6 shift intact", cap, 8'hC3);
    cpu_rd(2'd1, d); chk(d == 8'hC0, "R6 status", d, 8'hC0);
    cpu_rd(2'd2, d); chk(d == 8'h5A, "R6 rx byte", d, 8'h5A);
    cpu_rd(2'd1, d); chk(d == 8'h00, "R10 flags cleared", d, 0);
    cpu_rd(2'd2, d);
  endtask

  task automatic slave_byte(input bit cpol, input bit cpha, input bit lsbf, input logic [7:0] tx,
                            input logic [7:0] pat, input int nbits, output logic [7:0] got);
    got = '0;
    ss_n_i = 1'b1; sclk_i = cpol;
    cpu_wr(2'd0, {1'b1, 1'b0, cpol, cpha, lsbf, 1'b1, 2'b00});
    repeat (6) @(negedge clk);
    cpu_wr(2'd2, tx);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!cpha) begin
        mosi_i = pat[ord(lsbf, i)];
        repeat (8) @(negedge clk);
        got[ord(lsbf, i)] = miso_o;
        sclk_i = ~cpol;
        repeat (8) @(negedge clk);
        sclk_i = cpol;
      end else begin
        sclk_i = ~cpol;
        mosi_i = pat[ord(lsbf, i)];
        repeat (8) @(negedge clk);
        got[ord(lsbf, i)] = miso_o;
        sclk_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave(input bit cpol, input bit cpha, input bit lsbf,
                         input logic [7:0] tx, input logic [7:0] pat);
    logic [7:0] got, d;
    slave_byte(cpol, cpha, lsbf, tx, pat, 8, got);
    chk(got == tx, "R7 miso byte", got, tx);
    chk(irq == 1'b1, "R11 slave irq", irq, 1);
    cpu_rd(2'd1, d); chk(d == 8'h80, "R7 status", d, 8'h80);
    cpu_rd(2'd2, d); chk(d == pat, "R7 mosi byte", d, pat);
  endtask

  task automatic t_abort();
    logic [7:0] got, d;
    slave_byte(0, 0, 0, 8'h11, 8'hF0, 4, got);
    chk(irq == 1'b0, "R9 no done on abort", irq, 0);
    cpu_rd(2'd1, d); chk(d == 8'h00, "R9 status after abort", d, 0);
    slave_byte(0, 0, 0, 8'h22, 8'h6B, 8, got);
    cpu_rd(2'd1, d); chk(d == 8'h80, "R9 next byte done", d, 8'h80);
    cpu_rd(2'd2, d); chk(d == 8'h6B, "R9 next byte data", d, 8'h6B);
  endtask

  task automatic t_overflow();
    logic [7:0] got, d;
    slave_byte(1, 0, 0, 8'h33, 8'hA1, 8, got);
    slave_byte(1, 0, 0, 8'h44, 8'h7E, 8, got);
    cpu_rd(2'd1, d); chk(d == 8'hA0, "R8 overflow status", d, 8'hA0);
    cpu_rd(2'd2, d); chk(d == 8'hA1, "R8 buffer keeps first", d, 8'hA1);
  endtask

  task automatic t_clear_order();
    logic [7:0] got, d;
    slave_byte(0, 1, 0, 8'h55, 8'h3D, 8, got);
    cpu_rd(2'd2, d);
    chk(d == 8'h3D, "R10 data read", d, 8'h3D);
    chk(irq == 1'b1, "R10 not cleared without status read", irq, 1);
    cpu_rd(2'd1, d);
    cpu_rd(2'd2, d);
    chk(irq == 1'b0, "R10 cleared after sequence", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_master(0, 0, 0, 2'd0, 8'hA5, 8'h3C);
    t_master(1, 0, 0, 2'd1, 8'h96, 8'hE1);
    t_master(0, 1, 1, 2'd2, 8'h1F, 8'hB2);
    t_master(1, 1, 1, 2'd3, 8'h68, 8'h0D);
    t_collision();
    t_slave(0, 0, 0, 8'hC6, 8'h29);
    t_slave(1, 1, 1, 8'h8B, 8'hD4);
    t_slave(0, 1, 1, 8'h17, 8'hE8);
    flush();
    t_abort();
    flush();
    t_overflow();
    flush();
    t_clear_order();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule